// File: doc/BRIEF.md
# Channel-Masked CUSUM Band-Power Detector

This block watches relative band-power values that arrive one channel at a time from a channel-interleaved spectral engine. Each value carries a channel tag. A channel enable bitmap decides whether a value is used or dropped. One shared arithmetic path serves every channel. Each channel keeps its own cumulative-sum (CUSUM) statistic in a small per-channel store.

The block has two phases. In the training phase it learns a single baseline from seizure-free data: it sums a power-of-two count of accepted values and shifts the sum right to form their average. When training ends, that average becomes the reference. In the detection phase, each accepted value pushes its channel's statistic up by how far it exceeds the reference plus a drift allowance. The statistic never drops below zero. When any statistic passes a programmable threshold, a sticky stimulator trigger is raised. An acknowledge clears the trigger and all statistics.

Top module: `cusum_band_detector`

## Requirements
- R1: After reset, `trigger`, `training` and `baseline` are all 0, every channel is enabled (the bitmap is all ones), and every statistic is 0.
- R2: Bit c of the bitmap governs channel c. When the bit is 1, a value tagged c is used. When the bit is 0, the value is discarded: it changes no statistic and is not counted in training. A bitmap write (`mask_we`) takes effect for values presented from the next cycle onward.
- R3: A `train_start` pulse enters training, and `training` is 1 from the next cycle. Training collects 2^k accepted values. At the edge that accepts the last of them, `baseline` becomes floor(sum / 2^k) and `training` returns to 0.
- R4: `train_start` clears every statistic and the trigger. No statistic is updated while training, or before the first training has completed.
- R5: In detection, an accepted value x on channel c sets S[c] = max(0, S[c] + x − baseline − drift). S[c] saturates at 2^ACC_W − 1 instead of wrapping.
- R6: `trigger` rises at the clock edge where an updated statistic becomes strictly greater than `threshold`. It then stays high until it is cleared.
- R7: `trig_ack` clears the trigger and every statistic at the next edge. A value presented in the same cycle as the acknowledge is discarded.
- R8: Each channel's statistic evolves independently: values on one channel never change another channel's statistic.
- R9: The training length exponent `train_log2` is captured at `train_start`. Changing it during training has no effect on that training run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Power value present this cycle |
| in_chan | input | CH_W | Channel tag of the value |
| in_power | input | DATA_W | Relative band power, unsigned |
| mask_we | input | 1 | Write strobe for the channel bitmap |
| mask_wdata | input | NCH | New bitmap, one bit per channel |
| train_start | input | 1 | Start a training run |
| train_log2 | input | LOG_W | Training length exponent k (2^k values) |
| drift | input | DATA_W | Drift allowance subtracted each step |
| threshold | input | ACC_W | Trigger threshold on the statistic |
| trig_ack | input | 1 | Acknowledge: clear trigger and statistics |
| trigger | output | 1 | Sticky stimulator trigger |
| training | output | 1 | High while the training phase is active |
| baseline | output | DATA_W | Learned reference value |

## Verification
The hardest case to reach from the ports is statistic saturation. With the default width, a statistic reaches its ceiling only after about 257 back-to-back near-full-scale values on one channel. The bench therefore sets the threshold to the ceiling itself and streams 260 maximal values, checking that the trigger stays low. It then lowers the threshold by two and sends one value exactly equal to baseline plus drift. The trigger can fire on that value only if the statistic is pinned at its ceiling, and would stay low if the statistic had wrapped. The bench also proves that masked values, values sent with an acknowledge, and values sent before training leave no trace. It does this by choosing later values that cross the threshold only if the earlier value had been wrongly accumulated.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    localparam int DEF_NCH    = 8;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_ACC_W  = 24;
    localparam int DEF_LOG_W  = 3;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_TRAIN  = 2'd1,
        MODE_DETECT = 2'd2
    } cbd_mode_e;

endpackage

// File: rtl/cbd_gate.sv
module cbd_gate #(
    parameter int NCH  = cbd_pkg::DEF_NCH,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_chan,
    input  logic            mask_we,
    input  logic [NCH-1:0]  mask_wdata,
    output logic            accept
);

    logic [NCH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign accept = in_valid && (int'(in_chan) < NCH) && mask_q[in_chan];

endmodule

// File: rtl/cbd_trainer.sv
module cbd_trainer #(
    parameter int DATA_W = cbd_pkg::DEF_DATA_W,
    parameter int LOG_W  = cbd_pkg::DEF_LOG_W,
    localparam int MAXK  = (1 << LOG_W) - 1,
    localparam int SUM_W = DATA_W + MAXK,
    localparam int CNT_W = MAXK + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              train_start,
    input  logic [LOG_W-1:0]  train_log2,
    input  logic              accept,
    input  logic [DATA_W-1:0] in_power,
    output logic              training,
    output logic              armed,
    output logic [DATA_W-1:0] baseline
);
    import cbd_pkg::*;

    cbd_mode_e        mode_q;
    logic [LOG_W-1:0] k_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_next;
    logic [CNT_W-1:0] last_cnt;
    logic             finish;

    assign sum_next = sum_q + SUM_W'(in_power);
    assign last_cnt = (CNT_W'(1) << k_q) - CNT_W'(1);
    assign finish   = (mode_q == MODE_TRAIN) && accept && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_IDLE;
            k_q      <= '0;
            sum_q    <= '0;
            cnt_q    <= '0;
            baseline <= '0;
        end else if (train_start) begin
            mode_q <= MODE_TRAIN;
            k_q    <= train_log2;
            sum_q  <= '0;
            cnt_q  <= '0;
        end else if (mode_q == MODE_TRAIN && accept) begin
            if (finish) begin
                baseline <= DATA_W'(sum_next >> k_q);
                mode_q   <= MODE_DETECT;
            end
            sum_q <= sum_next;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign training = (mode_q == MODE_TRAIN);
    assign armed    = (mode_q == MODE_DETECT);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        training |-> (cnt_q <= last_cnt));

    assert_train_ends_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(training) |-> ($past(accept) && !$past(train_start)));

    assert_baseline_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!train_start && !(training && accept)) |=> $stable(baseline));

    assert_k_held_R9: assert property (@(posedge clk) disable iff (rst)
        (training && !train_start) |=> $stable(k_q));

endmodule

// File: rtl/cbd_cusum_bank.sv
module cbd_cusum_bank #(
    parameter int NCH    = cbd_pkg::DEF_NCH,
    parameter int DATA_W = cbd_pkg::DEF_DATA_W,
    parameter int ACC_W  = cbd_pkg::DEF_ACC_W,
    parameter int CH_W   = $clog2(NCH),
    localparam int EXT_W = ACC_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              clear,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_power,
    input  logic [DATA_W-1:0] ref_val,
    input  logic [DATA_W-1:0] drift,
    input  logic [ACC_W-1:0]  threshold,
    output logic              trigger
);

    localparam logic [ACC_W-1:0] S_MAX = '1;

    logic [ACC_W-1:0] s_mem [NCH];
    logic [ACC_W-1:0] s_cur;
    logic [ACC_W-1:0] s_new;

    function automatic logic [ACC_W-1:0] cusum_step(
        input logic [ACC_W-1:0]  s,
        input logic [DATA_W-1:0] x,
        input logic [DATA_W-1:0] r,
        input logic [DATA_W-1:0] d
    );
        logic signed [EXT_W-1:0] t;
        t = $signed({2'b00, s}) + $signed(EXT_W'(x)) - $signed(EXT_W'(r)) - $signed(EXT_W'(d));
        if (t < 0)                              return '0;
        else if (t > $signed({2'b00, S_MAX}))   return S_MAX;
        else                                    return t[ACC_W-1:0];
    endfunction

    assign s_cur = s_mem[in_chan];
    assign s_new = cusum_step(s_cur, in_power, ref_val, drift);

    for (genvar c = 0; c < NCH; c++) begin : g_stat
        always_ff @(posedge clk) begin
            if (rst || clear)
                s_mem[c] <= '0;
            else if (upd_en && (int'(in_chan) == c))
                s_mem[c] <= s_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)                       trigger <= 1'b0;
        else if (upd_en && (s_new > threshold)) trigger <= 1'b1;
    end

    assert_clear_drops_trigger_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> !trigger);

    assert_rise_needs_update_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(trigger) |-> $past(upd_en));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (trigger && !clear) |=> trigger);

    assert_no_grow_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !clear) |=> $stable(s_mem[0]));

endmodule

// File: rtl/cusum_band_detector.sv
module cusum_band_detector #(
    parameter int NCH    = cbd_pkg::DEF_NCH,
    parameter int DATA_W = cbd_pkg::DEF_DATA_W,
    parameter int ACC_W  = cbd_pkg::DEF_ACC_W,
    parameter int LOG_W  = cbd_pkg::DEF_LOG_W,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_power,
    input  logic              mask_we,
    input  logic [NCH-1:0]    mask_wdata,
    input  logic              train_start,
    input  logic [LOG_W-1:0]  train_log2,
    input  logic [DATA_W-1:0] drift,
    input  logic [ACC_W-1:0]  threshold,
    input  logic              trig_ack,
    output logic              trigger,
    output logic              training,
    output logic [DATA_W-1:0] baseline
);

    logic accept;
    logic armed;
    logic upd_en;
    logic clear_all;

    cbd_gate #(.NCH(NCH), .CH_W(CH_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_chan    (in_chan),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .accept     (accept)
    );

    cbd_trainer #(.DATA_W(DATA_W), .LOG_W(LOG_W)) u_trainer (
        .clk         (clk),
        .rst         (rst),
        .train_start (train_start),
        .train_log2  (train_log2),
        .accept      (accept && !trig_ack),
        .in_power    (in_power),
        .training    (training),
        .armed       (armed),
        .baseline    (baseline)
    );

    assign clear_all = train_start || trig_ack;
    assign upd_en    = accept && armed && !clear_all;

    cbd_cusum_bank #(.NCH(NCH), .DATA_W(DATA_W), .ACC_W(ACC_W), .CH_W(CH_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .clear     (clear_all),
        .in_chan   (in_chan),
        .in_power  (in_power),
        .ref_val   (baseline),
        .drift     (drift),
        .threshold (threshold),
        .trigger   (trigger)
    );

    assert_idle_no_trigger_R4: assert property (@(posedge clk) disable iff (rst)
        (training && !trig_ack) |=> !$rose(trigger));

endmodule

// File: tb/cusum_band_detector_bench.sv
module cusum_band_detector_bench;

    localparam int NCH = 8, DATA_W = 16, ACC_W = 24, LOG_W = 3, CH_W = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, mask_we = 0, train_start = 0, trig_ack = 0;
    logic [CH_W-1:0]   in_chan = '0;
    logic [DATA_W-1:0] in_power = '0, drift = 16'd5;
    logic [NCH-1:0]    mask_wdata = '1;
    logic [LOG_W-1:0]  train_log2 = '0;
    logic [ACC_W-1:0]  threshold = 24'd50;
    logic              trigger, training;
    logic [DATA_W-1:0] baseline;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    cusum_band_detector u_cusum_band_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_power(in_power),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .train_start(train_start),
        .train_log2(train_log2), .drift(drift), .threshold(threshold), .trig_ack(trig_ack),
        .trigger(trigger), .training(training), .baseline(baseline)
    );

    // entry: {ack, valid, chan[2:0], power[15:0], expected trigger}
    localparam int NVEC = 10;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 3'd0, 16'd120, 1'b0},
        {1'b0, 1'b1, 3'd1, 16'd90,  1'b0},
        {1'b0, 1'b1, 3'd0, 16'd110, 1'b0},
        {1'b0, 1'b1, 3'd1, 16'd150, 1'b0},
        {1'b0, 1'b1, 3'd2, 16'd155, 1'b0},
        {1'b0, 1'b1, 3'd0, 16'd100, 1'b0},
        {1'b0, 1'b1, 3'd2, 16'd106, 1'b1},
        {1'b1, 1'b0, 3'd0, 16'd0,   1'b0},
        {1'b0, 1'b1, 3'd2, 16'd106, 1'b0},
        {1'b0, 1'b1, 3'd1, 16'd115, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [CH_W-1:0] ch, input logic [DATA_W-1:0] v);
        in_valid = 1; in_chan = ch; in_power = v;
        step();
        in_valid = 0;
    endtask

    task automatic ack();
        trig_ack = 1;
        step();
        trig_ack = 0;
    endtask

    task automatic start_train(input logic [LOG_W-1:0] k);
        train_start = 1; train_log2 = k;
        step();
        train_start = 0;
    endtask

    task automatic write_mask(input logic [NCH-1:0] m);
        mask_we = 1; mask_wdata = m;
        step();
        mask_we = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        rst = 0;
        step();
        chk("R1 trigger", trigger, 0);
        chk("R1 training", training, 0);
        chk("R1 baseline", baseline, 0);

        // R4: no detection before any training
        send(3'd0, 16'd1000);
        chk("R4 no detect before training", trigger, 0);

        // R2: disable channel 3, then train with k=2
        write_mask(8'hF7);
        start_train(3'd2);
        chk("R3 training entered", training, 1);
        send(3'd0, 16'd100);
        send(3'd3, 16'd5000);
        send(3'd1, 16'd104);
        send(3'd2, 16'd96);
        chk("R2 masked value not counted in training", training, 1);
        send(3'd0, 16'd100);
        chk("R3 training ends", training, 0);
        chk("R3 baseline average", baseline, 100);

        // R5 R6 R8 R7: table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] e;
            e = VEC[i];
            if (e[21]) ack();
            else send(e[19:17], e[16:1]);
            chk(e[21] ? "R7 ack clears" : "R5/R6/R8 table", trigger, 32'(e[0]));
        end

        // R2: channel 3 still masked, large value discarded
        send(3'd3, 16'd600);
        chk("R2 masked channel discarded", trigger, 0);
        write_mask(8'hFF);
        send(3'd3, 16'd140);
        chk("R2 re-enabled channel starts from zero", trigger, 0);

        // R7: value sent with ack is discarded
        trig_ack = 1; in_valid = 1; in_chan = 3'd0; in_power = 16'd1000;
        step();
        trig_ack = 0; in_valid = 0;
        chk("R7 value with ack dropped", trigger, 0);
        send(3'd0, 16'd130);
        chk("R7 statistic not fed by dropped value", trigger, 0);

        // R4: retraining clears statistics (S0 = 45 before)
        send(3'd0, 16'd125);
        chk("R4 pre-retrain below threshold", trigger, 0);
        start_train(3'd1);
        send(3'd0, 16'd100);
        chk("R4 no detection during training", trigger, 0);
        send(3'd0, 16'd100);
        chk("R3 baseline k=1", baseline, 100);
        send(3'd0, 16'd115);
        chk("R4 statistic cleared by train_start", trigger, 0);

        // R5: saturation
        threshold = 24'hFFFFFF;
        for (int i = 0; i < 260; i++) send(3'd0, 16'hFFFF);
        chk("R5 saturated never exceeds ceiling", trigger, 0);
        threshold = 24'hFFFFFD;
        send(3'd0, 16'd105);
        chk("R5 statistic held at ceiling", trigger, 1);

        // R9 and R4: k captured at start, trigger cleared by start
        start_train(3'd0);
        chk("R4 train_start clears trigger", trigger, 0);
        train_log2 = 3'd3;
        send(3'd1, 16'd2000);
        chk("R9 k captured at start", training, 0);
        chk("R9 baseline single value", baseline, 2000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule